// File: doc/BRIEF.md
# Serial Port Modem Control, Modem Status and Loopback

This block is the modem-handshake part of a PC-style serial port. A host reaches it through a simple register port. It holds an interrupt enable register, a modem control register and a modem status register. The four active-low modem inputs (clear to send, data set ready, ring indicator and carrier detect) are synchronised and inverted, so that status bits read 1 while a line is asserted. The four active-low modem outputs (data terminal ready, request to send and two general outputs) follow the control register.

The block sets change flags in the status register. Carrier, data set ready and clear to send flag any change. The ring flag is set only when ringing ends. While any flag is set and the modem interrupt is enabled, the block holds a modem interrupt request.

When the loopback bit is set, the status lines are taken from the control register and the external outputs are parked inactive. A byte written for transmission then lands straight in the receive holding register, and the receive and transmit interrupts behave as usual.

Outside loopback, transmit bytes leave on a valid/ready stream and receive bytes arrive on a second one. On the transmit side, `tx_valid` rises once the host writes a byte and stays high with `tx_data` unchanged until a cycle with `tx_ready` high. On the receive side, `rx_ready` is high only while the receive holding register is empty and loopback is off. A byte moves on any cycle where valid and ready are both high.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, the modem status register reads 0x00 while all pins are inactive, the control register reads 0x00, all four modem outputs are high, and all three interrupt requests are low.
- R2: With loopback off, control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `out1_n` and `out2_n` low when set and high when clear. Writes take effect the cycle after the write. Register addresses are: 0 data, 1 interrupt enable, 4 modem control, 6 modem status.
- R3: With loopback off, status bits 4, 5, 6 and 7 are the inverted, synchronised `cts_n`, `dsr_n`, `ri_n` and `dcd_n`.
- R4: Status bits 0, 1 and 3 are set on any change of the clear-to-send, data-set-ready and carrier status bits respectively.
- R5: Status bit 2 is set when status bit 6 goes from 1 to 0, which is when ringing ends. It is not set when ringing starts.
- R6: Reading the modem status register returns the flags and clears bits 3:0. A change detected in the same cycle as the read keeps its flag set.
- R7: `irq_modem` is high while any of status bits 3:0 is set and interrupt enable bit 3 is 1. It stays low otherwise.
- R8: With loopback on (control bit 4), status bit 4 follows control bit 1, bit 5 follows control bit 0, bit 6 follows control bit 2 and bit 7 follows control bit 3. The external modem inputs have no effect.
- R9: With loopback on, all four modem outputs are held high whatever control bits 3:0 hold.
- R10: With loopback on, a byte written to the data address appears in the receive holding register on the next cycle and raises `irq_rx` if enabled. Nothing is offered on the transmit stream.
- R11: With loopback off, a byte written to the data address is offered on `tx_valid`/`tx_data` and held stable until accepted. A data write while a byte is still pending is dropped.
- R12: `rx_ready` is high only when the receive holding register is empty and loopback is off. An accepted byte reads back from the data address, and the read empties the register. `irq_rx` is receive-full AND enable bit 0. `irq_tx` is transmit-holding-empty AND enable bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data and status reads) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Shifter accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive holding register can take a byte |
| rx_data | input | 8 | Received byte |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq_modem | output | 1 | Modem status interrupt request |
| irq_rx | output | 1 | Receive data available request |
| irq_tx | output | 1 | Transmit holding empty request |

## Verification
The bench drives the ring line through a full ring cycle. It checks that the flag and the interrupt stay clear at the start of ringing and appear only at the end. A design that used the pin edge the wrong way round, or flagged both edges, would report the ring flag too early. The bench toggles external inputs while loopback is on and expects no effect on the status register. It also checks that entering and leaving loopback raises change flags for the lines whose value jumped, which a design with a wrong mapping would miss or flag wrongly. Finally, it writes a second transmit byte while the first is still pending and checks that the scoreboard sees only the first byte. A design that overwrote the pending byte would be caught there.

// File: rtl/uart_ms_pkg.sv
package uart_ms_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;
  // modem line bundle, active high; packed order matches status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;
endpackage

// File: rtl/ms_pin_sync.sv
module ms_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ms_status_track.sv
module ms_status_track
  import uart_ms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mline_t     line_now,
  input  logic       stat_rd,
  output logic [3:0] delta
);
  mline_t     prev;
  logic [3:0] hit;

  always_comb begin
    hit[0] = line_now.cts ^ prev.cts;
    hit[1] = line_now.dsr ^ prev.dsr;
    hit[2] = prev.ri & ~line_now.ri;   // trailing edge of ringing only
    hit[3] = line_now.dcd ^ prev.dcd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      delta <= '0;
    end else begin
      prev  <= line_now;
      delta <= stat_rd ? hit : (delta | hit);
    end
  end

  // R4
  cts_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_now.cts != prev.cts) |=> delta[0]);
  // R5
  ri_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta[2] && !(prev.ri && !line_now.ri)) |=> !delta[2]);
  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && hit == 4'd0) |=> delta == 4'd0);
endmodule

// File: rtl/ms_byte_path.sv
module ms_byte_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop,
  input  logic          wr_byte,
  input  logic [DW-1:0] wdata,
  input  logic          rd_byte,
  output logic [DW-1:0] rbr,
  output logic          rbr_full,
  output logic          thr_empty,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data
);
  logic thr_full;

  assign tx_valid  = thr_full;
  assign thr_empty = ~thr_full;
  assign rx_ready  = ~rbr_full & ~loop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_full <= 1'b0;
      tx_data  <= '0;
    end else if (thr_full) begin
      if (tx_ready) thr_full <= 1'b0;
    end else if (wr_byte && !loop) begin
      thr_full <= 1'b1;
      tx_data  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_full <= 1'b0;
      rbr      <= '0;
    end else if (loop && wr_byte) begin
      rbr_full <= 1'b1;
      rbr      <= wdata;
    end else if (rx_valid && rx_ready) begin
      rbr_full <= 1'b1;
      rbr      <= rx_data;
    end else if (rd_byte) begin
      rbr_full <= 1'b0;
    end
  end

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10
  loop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && wr_byte) |=> (rbr_full && !$rose(tx_valid)));
  // R12
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (rbr_full && rbr == $past(rx_data)));
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_ms_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq_modem,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [4:0]        mctl;        // 0 dtr, 1 rts, 2 out1, 3 out2, 4 loop
  logic              en_rx, en_tx, en_ms;
  logic [3:0]        pins_q;
  mline_t            ext_line, loop_line, line_now;
  logic [3:0]        delta;
  logic [DATA_W-1:0] rbr;
  logic              rbr_full, thr_empty;
  logic              loop;

  assign loop = mctl[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl  <= '0;
      en_rx <= 1'b0;
      en_tx <= 1'b0;
      en_ms <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_MCTL) mctl <= reg_wdata[4:0];
      if (reg_addr == A_IEN) begin
        en_rx <= reg_wdata[0];
        en_tx <= reg_wdata[1];
        en_ms <= reg_wdata[3];
      end
    end
  end

  ms_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dcd_n, ri_n, dsr_n, cts_n}),
    .dout (pins_q)
  );

  always_comb begin
    ext_line      = mline_t'(~pins_q);
    loop_line.cts = mctl[1];
    loop_line.dsr = mctl[0];
    loop_line.ri  = mctl[2];
    loop_line.dcd = mctl[3];
    line_now      = loop ? loop_line : ext_line;
  end

  ms_status_track u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_now(line_now),
    .stat_rd (reg_rd && reg_addr == A_MSTAT),
    .delta   (delta)
  );

  ms_byte_path #(.DW(DATA_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop     (loop),
    .wr_byte  (reg_wr && reg_addr == A_DATA),
    .wdata    (reg_wdata),
    .rd_byte  (reg_rd && reg_addr == A_DATA),
    .rbr      (rbr),
    .rbr_full (rbr_full),
    .thr_empty(thr_empty),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
  );

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rbr;
      A_IEN:   reg_rdata = {4'b0, en_ms, 1'b0, en_tx, en_rx};
      A_MCTL:  reg_rdata = {3'b0, mctl};
      A_MSTAT: reg_rdata = {line_now, delta};
      default: reg_rdata = '0;
    endcase
  end

  assign dtr_n  = loop | ~mctl[0];
  assign rts_n  = loop | ~mctl[1];
  assign out1_n = loop | ~mctl[2];
  assign out2_n = loop | ~mctl[3];

  assign irq_modem = en_ms & (|delta);
  assign irq_rx    = en_rx & rbr_full;
  assign irq_tx    = en_tx & thr_empty;

  // R5
  ring_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(line_now.ri) && en_ms) |=> irq_modem);
endmodule

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic       rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic       cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic       dtr_n, rts_n, out1_n, out2_n;
  logic       irq_modem, irq_rx, irq_tx;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] v;

  always #5 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d);
    exp_q.push_back(d);
    wr(3'd0, d);
  endtask

  // scoreboard monitor: handshake happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected tx", tx_data, 8'h00);
      else check("R11 tx byte", tx_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd6, v); check("R1 status", v, 8'h00);
    rd(3'd4, v); check("R1 control", v, 8'h00);
    check("R1 outputs", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    check("R1 irqs", {5'b0, irq_modem, irq_rx, irq_tx}, 8'h00);

    // R2 outputs follow control
    wr(3'd4, 8'h05);
    check("R2 outputs", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h05);

    // R3/R4 clear to send asserted
    cts_n = 0; settle();
    rd(3'd6, v); check("R3 R4 cts", v, 8'h11);
    rd(3'd6, v); check("R6 cleared", v, 8'h10);

    // R7 with enable
    wr(3'd1, 8'h08);
    dsr_n = 0; dcd_n = 0; settle();
    check("R7 irq on", {7'b0, irq_modem}, 8'h01);
    rd(3'd6, v); check("R4 dsr dcd", v, 8'hBA);
    check("R7 irq off after read", {7'b0, irq_modem}, 8'h00);

    // R5 ring start: no flag
    ri_n = 0; settle();
    check("R5 no irq at ring start", {7'b0, irq_modem}, 8'h00);
    rd(3'd6, v); check("R5 ring start", v, 8'hF0);
    ri_n = 1; settle();
    check("R5 irq at ring end", {7'b0, irq_modem}, 8'h01);
    rd(3'd6, v); check("R5 ring end", v, 8'hB4);

    // R7 disabled
    wr(3'd1, 8'h00);
    cts_n = 1; settle();
    check("R7 masked", {7'b0, irq_modem}, 8'h00);
    rd(3'd6, v); check("R4 cts release", v, 8'hA1);

    // R8/R9 loopback
    wr(3'd4, 8'h13);
    check("R9 outputs parked", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    rd(3'd6, v); check("R8 enter loop", v, 8'h39);
    dsr_n = 1; cts_n = 0; settle();
    rd(3'd6, v); check("R8 pins ignored", v, 8'h30);
    wr(3'd4, 8'h17);
    check("R9 outputs still parked", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    rd(3'd6, v); check("R8 R5 loop ring start", v, 8'h70);
    wr(3'd4, 8'h13);
    rd(3'd6, v); check("R8 R5 loop ring end", v, 8'h34);

    // R10 loopback data
    wr(3'd1, 8'h03);
    check("R12 rx_ready low in loop", {7'b0, rx_ready}, 8'h00);
    wr(3'd0, 8'hA5);
    check("R10 irq_rx", {7'b0, irq_rx}, 8'h01);
    check("R10 no tx", {7'b0, tx_valid}, 8'h00);
    check("R10 irq_tx", {7'b0, irq_tx}, 8'h01);
    rd(3'd0, v); check("R10 loop byte", v, 8'hA5);
    check("R12 irq_rx cleared", {7'b0, irq_rx}, 8'h00);

    // leave loopback: pins cts_n=0 dsr_n=1 ri_n=1 dcd_n=0 -> 0x90
    wr(3'd4, 8'h00);
    rd(3'd6, v); check("R8 exit loop", v, 8'h9A);

    // R11 transmit stream with back-pressure
    tx_ready = 0;
    send(8'h3C);
    wr(3'd0, 8'h77);            // dropped while pending
    check("R12 irq_tx full", {7'b0, irq_tx}, 8'h00);
    repeat (3) @(negedge clk);
    check("R11 held", tx_data, 8'h3C);
    tx_ready = 1;
    repeat (2) @(negedge clk);
    send(8'h5A);
    repeat (3) @(negedge clk);
    check("R11 queue drained", 8'(exp_q.size()), 8'h00);
    check("R12 irq_tx empty", {7'b0, irq_tx}, 8'h01);
    tx_ready = 0;

    // R12 receive stream
    check("R12 rx_ready idle", {7'b0, rx_ready}, 8'h01);
    @(negedge clk); rx_valid = 1; rx_data = 8'h42;
    @(negedge clk); rx_valid = 0;
    check("R12 rx_ready full", {7'b0, rx_ready}, 8'h00);
    check("R12 irq_rx", {7'b0, irq_rx}, 8'h01);
    rd(3'd0, v); check("R12 rx byte", v, 8'h42);
    check("R12 rx_ready again", {7'b0, rx_ready}, 8'h01);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule